// File: doc/BRIEF.md
# Sweep Averaging Quadrature Accumulator

This block collects one point of a swept transfer-function measurement. A one-cycle `start` pulse, issued whenever the excitation frequency is changed, begins a new acquisition. The block first idles for a programmed number of settling cycles so the filtered quadratures can follow the new frequency. It then adds the in-phase and quadrature samples into two wide signed sums over a programmed number of cycles. When that window closes it holds both sums until the next `start`.

Each 62-bit sum is presented as two 32-bit words. Bits 30:0 of the low word carry sum bits 30:0. Bits 30:0 of the high word carry sum bits 61:31, so the value is low + (high << 31). Bit 31 of all four words is a not-ready flag. It reads 1 while the block is settling or summing and 0 once the result is final. Software polls until the flag is clear, then divides by the average count and normalises. Both cycle counts are sampled when `start` is seen, so later changes to them do not disturb a running acquisition.

Top module: `sweep_quad_accum`

## Requirements
- R1: After a synchronous reset, all four readout words read 0, with the flag clear and the sums zero.
- R2: The edge that samples `start` clears both sums. From the second edge after it, bit 31 of every word reads 1 whenever the sleep or average count is non-zero.
- R3: For the S cycles after the `start` edge, where S is the sleep count, no sample is added.
- R4: After the sleep, the samples present on exactly A consecutive rising edges are added, where A is the average count. Each sample is a 24-bit two's-complement value, sign-extended to 62 bits.
- R5: Word layout: `rd_i_lo`[30:0] = I sum[30:0] and `rd_i_hi`[30:0] = I sum[61:31]. `rd_q_lo` and `rd_q_hi` follow the same layout for Q. Readout words lag the internal state by one register stage.
- R6: Once the A samples have been added, bit 31 of all four words reads 0. The words then stay constant, whatever the sample inputs do, until the next `start`.
- R7: An average count of 0 completes as soon as the sleep ends, with both sums zero. If the sleep count is also 0, it completes on the `start` edge itself.
- R8: A `start` during settling or summing clears both sums and restarts the sleep phase from the beginning, using the count values present at that moment.
- R9: A sleep count of 0 makes summing begin with the sample on the first edge after the `start` edge.
- R10: Changes to `sleep_cycles` or `avg_cycles` after the `start` edge do not alter the running acquisition.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle pulse on a frequency write; begins an acquisition |
| sleep_cycles | input | 32 | Settling cycles before summing |
| avg_cycles | input | 32 | Number of samples to sum |
| i_sample | input | 24 | In-phase sample, signed |
| q_sample | input | 24 | Quadrature sample, signed |
| rd_i_lo | output | 32 | Not-ready flag and I sum bits 30:0 |
| rd_i_hi | output | 32 | Not-ready flag and I sum bits 61:31 |
| rd_q_lo | output | 32 | Not-ready flag and Q sum bits 30:0 |
| rd_q_hi | output | 32 | Not-ready flag and Q sum bits 61:31 |

## Verification
The assertions assume that `start` is a one-cycle pulse on a clean clock, and that the counts and samples are stable around each rising edge. They also assume the sums never wrap within 62 bits, which would take more than 2^38 full-scale samples. The stimulus drives all inputs on the falling edge. It uses sleep and average counts below 64 and mixes random samples with runs of the most negative and most positive 24-bit codes. It fires retriggers in both the settling and the summing phase, and changes the counts mid-run to probe R10.

// File: rtl/sqa_pkg.sv
package sqa_pkg;
  typedef enum logic [1:0] {
    PH_DONE  = 2'd0,
    PH_SLEEP = 2'd1,
    PH_ACCUM = 2'd2
  } sqa_phase_e;
endpackage

// File: rtl/sqa_sequencer.sv
module sqa_sequencer
  import sqa_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] sleep_cycles,
  input  logic [CNT_W-1:0] avg_cycles,
  output sqa_phase_e       phase,
  output logic             clear,
  output logic             add_en
);
  logic [CNT_W-1:0] cnt, cnt_nxt, sleep_q, avg_q;

  assign cnt_nxt = cnt + 1'b1;
  assign clear   = start;
  assign add_en  = (phase == PH_ACCUM) && !start;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_DONE;
      cnt     <= '0;
      sleep_q <= '0;
      avg_q   <= '0;
    end else if (start) begin
      sleep_q <= sleep_cycles;
      avg_q   <= avg_cycles;
      cnt     <= '0;
      if (sleep_cycles != '0)    phase <= PH_SLEEP;
      else if (avg_cycles != '0) phase <= PH_ACCUM;
      else                       phase <= PH_DONE;
    end else begin
      unique case (phase)
        PH_SLEEP: begin
          if (cnt_nxt == sleep_q) begin
            cnt   <= '0;
            phase <= (avg_q != '0) ? PH_ACCUM : PH_DONE;
          end else begin
            cnt <= cnt_nxt;
          end
        end
        PH_ACCUM: begin
          if (cnt_nxt == avg_q) begin
            cnt   <= '0;
            phase <= PH_DONE;
          end else begin
            cnt <= cnt_nxt;
          end
        end
        default: cnt <= '0;
      endcase
    end
  end
endmodule

// File: rtl/sqa_accum.sv
module sqa_accum #(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 62
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clear,
  input  logic              add_en,
  input  logic [DATA_W-1:0] sample,
  output logic [ACC_W-1:0]  sum
);
  localparam int EXT_W = ACC_W - DATA_W;
  logic [ACC_W-1:0] ext;

  assign ext = {{EXT_W{sample[DATA_W-1]}}, sample};

  always_ff @(posedge clk) begin
    if (rst || clear) sum <= '0;
    else if (add_en)  sum <= sum + ext;
  end
endmodule

// File: rtl/sqa_readout.sv
module sqa_readout #(
  parameter int ACC_W  = 62,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              busy,
  input  logic [ACC_W-1:0]  sum,
  output logic [WORD_W-1:0] word_lo,
  output logic [WORD_W-1:0] word_hi
);
  localparam int HALF = WORD_W - 1;

  always_ff @(posedge clk) begin
    if (rst) begin
      word_lo <= '0;
      word_hi <= '0;
    end else begin
      word_lo <= {busy, sum[HALF-1:0]};
      word_hi <= {busy, sum[ACC_W-1:HALF]};
    end
  end
endmodule

// File: rtl/sweep_quad_accum.sv
module sweep_quad_accum
  import sqa_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int ACC_W  = 62,
  parameter int CNT_W  = 32,
  parameter int WORD_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [CNT_W-1:0]  sleep_cycles,
  input  logic [CNT_W-1:0]  avg_cycles,
  input  logic [DATA_W-1:0] i_sample,
  input  logic [DATA_W-1:0] q_sample,
  output logic [WORD_W-1:0] rd_i_lo,
  output logic [WORD_W-1:0] rd_i_hi,
  output logic [WORD_W-1:0] rd_q_lo,
  output logic [WORD_W-1:0] rd_q_hi
);
  localparam int NCH = 2;

  sqa_phase_e        phase;
  logic              clear, add_en, busy, sleeping;
  logic [DATA_W-1:0] samp [NCH];
  logic [ACC_W-1:0]  sums [NCH];
  logic [WORD_W-1:0] lo   [NCH];
  logic [WORD_W-1:0] hi   [NCH];

  assign samp[0]  = i_sample;
  assign samp[1]  = q_sample;
  assign busy     = (phase != PH_DONE);
  assign sleeping = (phase == PH_SLEEP);

  sqa_sequencer #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .sleep_cycles(sleep_cycles), .avg_cycles(avg_cycles),
    .phase(phase), .clear(clear), .add_en(add_en)
  );

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    sqa_accum #(.DATA_W(DATA_W), .ACC_W(ACC_W)) u_acc (
      .clk(clk), .rst(rst), .clear(clear), .add_en(add_en),
      .sample(samp[c]), .sum(sums[c])
    );
    sqa_readout #(.ACC_W(ACC_W), .WORD_W(WORD_W)) u_rd (
      .clk(clk), .rst(rst), .busy(busy), .sum(sums[c]),
      .word_lo(lo[c]), .word_hi(hi[c])
    );
  end

  assign rd_i_lo = lo[0];
  assign rd_i_hi = hi[0];
  assign rd_q_lo = lo[1];
  assign rd_q_hi = hi[1];
endmodule

// File: rtl/sqa_checker.sv
module sqa_checker #(
  parameter int ACC_W  = 62,
  parameter int CNT_W  = 32,
  parameter int WORD_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              start,
  input logic [CNT_W-1:0]  sleep_cycles,
  input logic [CNT_W-1:0]  avg_cycles,
  input logic              busy,
  input logic              sleeping,
  input logic [ACC_W-1:0]  sum_i,
  input logic [ACC_W-1:0]  sum_q,
  input logic [WORD_W-1:0] rd_i_lo,
  input logic [WORD_W-1:0] rd_i_hi,
  input logic [WORD_W-1:0] rd_q_lo,
  input logic [WORD_W-1:0] rd_q_hi
);
  p_flags_agree_r6: assert property (@(posedge clk) disable iff (rst)
    (rd_i_lo[WORD_W-1] == rd_i_hi[WORD_W-1]) &&
    (rd_i_lo[WORD_W-1] == rd_q_lo[WORD_W-1]) &&
    (rd_i_lo[WORD_W-1] == rd_q_hi[WORD_W-1]));

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start && (sleep_cycles != '0 || avg_cycles != '0) |=> busy);

  p_start_clear_r8: assert property (@(posedge clk) disable iff (rst)
    start |=> (sum_i == '0) && (sum_q == '0));

  p_sleep_no_add_r3: assert property (@(posedge clk) disable iff (rst)
    sleeping && !start |=> $stable(sum_i) && $stable(sum_q));

  p_done_hold_r6: assert property (@(posedge clk) disable iff (rst)
    !busy && !start |=> !busy && $stable(sum_i) && $stable(sum_q));

  p_avg_zero_r7: assert property (@(posedge clk) disable iff (rst)
    start && sleep_cycles == '0 && avg_cycles == '0 |=> !busy && sum_i == '0);
endmodule

bind sweep_quad_accum sqa_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst(rst), .start(start),
  .sleep_cycles(sleep_cycles), .avg_cycles(avg_cycles),
  .busy(busy), .sleeping(sleeping),
  .sum_i(sums[0]), .sum_q(sums[1]),
  .rd_i_lo(rd_i_lo), .rd_i_hi(rd_i_hi), .rd_q_lo(rd_q_lo), .rd_q_hi(rd_q_hi)
);

// File: tb/sweep_quad_accum_tb.sv
module sweep_quad_accum_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start = 1'b0;
  logic [31:0] sleep_cycles = 32'd0;
  logic [31:0] avg_cycles = 32'd0;
  logic [23:0] i_sample = 24'd0;
  logic [23:0] q_sample = 24'd0;
  logic [31:0] rd_i_lo, rd_i_hi, rd_q_lo, rd_q_hi;

  always #2.5 clk = ~clk;

  sweep_quad_accum u_dut (
    .clk(clk), .rst(rst), .start(start),
    .sleep_cycles(sleep_cycles), .avg_cycles(avg_cycles),
    .i_sample(i_sample), .q_sample(q_sample),
    .rd_i_lo(rd_i_lo), .rd_i_hi(rd_i_hi), .rd_q_lo(rd_q_lo), .rd_q_hi(rd_q_hi)
  );

  int    n_cmp = 0, n_bad = 0, cyc = 0;
  string cur_tag = "R1";
  int    mode = 0;  // 0 random, 1 min code, 2 max code, 3 hold zero

  // behavioural reference: 0 done, 1 sleeping, 2 summing
  int     m_ph = 0, m_cnt = 0, m_sl = 0, m_av = 0;
  longint m_ai = 0, m_aq = 0;
  logic [31:0] e_ilo = 0, e_ihi = 0, e_qlo = 0, e_qhi = 0;

  always @(posedge clk) begin
    if (rst) begin
      m_ph = 0; m_cnt = 0; m_ai = 0; m_aq = 0; m_sl = 0; m_av = 0;
      e_ilo = 0; e_ihi = 0; e_qlo = 0; e_qhi = 0;
    end else begin
      logic bz;
      bz = (m_ph != 0);
      e_ilo = {bz, m_ai[30:0]}; e_ihi = {bz, m_ai[61:31]};
      e_qlo = {bz, m_aq[30:0]}; e_qhi = {bz, m_aq[61:31]};
      if (start) begin
        m_sl = int'(sleep_cycles); m_av = int'(avg_cycles);
        m_ai = 0; m_aq = 0; m_cnt = 0;
        m_ph = (m_sl != 0) ? 1 : (m_av != 0) ? 2 : 0;
      end else if (m_ph == 1) begin
        m_cnt++;
        if (m_cnt == m_sl) begin m_cnt = 0; m_ph = (m_av != 0) ? 2 : 0; end
      end else if (m_ph == 2) begin
        m_ai += longint'($signed(i_sample));
        m_aq += longint'($signed(q_sample));
        m_cnt++;
        if (m_cnt == m_av) begin m_cnt = 0; m_ph = 0; end
      end
    end
  end

  task automatic cmp(input string what, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s at cycle %0d: actual %h expected %h", cur_tag, what, cyc, act, exp);
    end
  endtask

  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      cmp("i_lo", rd_i_lo, e_ilo); cmp("i_hi", rd_i_hi, e_ihi);
      cmp("q_lo", rd_q_lo, e_qlo); cmp("q_hi", rd_q_hi, e_qhi);
    end
    case (mode)
      1: begin i_sample = 24'h800000; q_sample = 24'h800000; end
      2: begin i_sample = 24'h7FFFFF; q_sample = 24'h7FFFFF; end
      3: begin i_sample = 24'd0; q_sample = 24'd0; end
      default: begin i_sample = 24'($urandom); q_sample = 24'($urandom); end
    endcase
    if (cyc > 150000) begin
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  task automatic kick(input int s, input int a);
    @(negedge clk);
    sleep_cycles = 32'(s); avg_cycles = 32'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    repeat (3) @(negedge clk);
    while (rd_i_lo[31] && guard < 5000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    cur_tag = "R1";
    cmp("reset i_lo", rd_i_lo, 32'd0); cmp("reset q_hi", rd_q_hi, 32'd0);

    cur_tag = "R2"; kick(5, 20); wait_done();
    cur_tag = "R3"; kick(17, 3); wait_done();
    cur_tag = "R4"; mode = 1; kick(2, 40); wait_done();
    mode = 2; kick(1, 33); wait_done();
    cur_tag = "R5"; mode = 0; kick(3, 60); wait_done();
    cur_tag = "R9"; kick(0, 9); wait_done();
    kick(0, 1); wait_done();
    cur_tag = "R7"; kick(4, 0); wait_done();
    kick(0, 0); repeat (4) @(negedge clk);
    cmp("avg0 i_lo", rd_i_lo, 32'd0);
    cur_tag = "R8"; kick(6, 30); repeat (3) @(negedge clk);
    kick(4, 10); repeat (8) @(negedge clk);
    kick(2, 12); wait_done();
    cur_tag = "R10"; kick(5, 25);
    sleep_cycles = 32'd1; avg_cycles = 32'd2;
    repeat (10) @(negedge clk);
    avg_cycles = 32'd0; wait_done();
    cur_tag = "R6"; mode = 0; repeat (40) @(negedge clk);
    mode = 1; repeat (10) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule